// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides when a small 8-bit CPU core leaves its instruction stream to service an interrupt, and which service routine it enters. It collects eight sources: a software-trap instruction, an external asynchronous request line, three timer requests (input capture, output compare, counter overflow), a serial-port request, and two core-timer requests (counter overflow and a periodic real-time tick). Hardware requests are qualified by a per-source enable and by a global mask bit. The software trap ignores both.

Decisions are made only when the CPU strobes `instr_done` to mark an instruction boundary. A request that arrives mid-instruction therefore waits. When an interrupt is taken, the block pulses `take_int` for one cycle. That pulse is the CPU's cue to push its registers. At the same time the block presents the 12-bit vector-fetch address, sets the mask, and pushes the previous mask value onto a small internal stack. An `rti` strobe pops that stack back into the mask. The CPU's own mask set/clear instructions reach the block through `ibit_wr`/`ibit_val`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A synchronous reset drives `take_int` to 0, `mask_bit` to 1 and `vector_addr` to 0xFFE (reset vector), clears the external pending flag and fills the mask stack with ones.
- R2: An interrupt is taken only at a clock edge where `instr_done` is 1. `take_int` is 1 for exactly the cycle after that edge. A request present while `instr_done` is 0 produces no `take_int` and is still serviced at the next boundary.
- R3: A hardware source is eligible only if its request is active, its `src_en` bit is 1 and `mask_bit` is 0. The `src_en` bit order is: 0 external, 1 capture, 2 compare, 3 timer overflow, 4 serial, 5 core-timer overflow, 6 real-time tick. An ineligible request gives no `take_int`.
- R4: `swi_req` sampled with `instr_done` always causes a take to vector 0xFFC, whatever `mask_bit` and `src_en` hold.
- R5: On every take, `mask_bit` reads 1 in the same cycle that `take_int` is 1.
- R6: Vectors are software trap 0xFFC, external 0xFFA, capture/compare/timer overflow 0xFF8, serial 0xFF6, core-timer overflow/tick 0xFF4. When several sources are eligible, the one with the highest vector address wins. `vector_addr` holds its value between takes.
- R7: A rising edge on `ext_irq` sets a sticky pending flag through a two-stage synchronizer. The flag can be taken from the fourth clock edge after the input rises. It stays set while disabled or masked and is cleared only when the external vector is taken.
- R8: `rti` loads `mask_bit` with the mask value saved by the most recent unreturned take (nesting depth `NEST_DEPTH`). An `rti` with nothing saved yields 1.
- R9: `ibit_wr` loads `mask_bit` from `ibit_val` on the next edge when no take and no `rti` occur in that cycle.
- R10: In a cycle where an interrupt is taken, `ibit_wr` and `rti` have no effect on `mask_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Instruction-boundary strobe from the CPU |
| swi_req | input | 1 | Software-trap instruction is completing |
| ext_irq | input | 1 | External asynchronous request, rising-edge sensitive |
| tmr_req | input | 3 | Timer requests: bit0 capture, bit1 compare, bit2 overflow |
| sci_req | input | 1 | Serial-port request |
| ctm_req | input | 2 | Core-timer requests: bit0 overflow, bit1 real-time tick |
| src_en | input | 7 | Per-source enables for the hardware sources |
| ibit_wr | input | 1 | Mask write strobe from the CPU |
| ibit_val | input | 1 | Value written to the mask |
| rti | input | 1 | Return-from-interrupt strobe |
| take_int | output | 1 | One-cycle interrupt entry pulse (register save request) |
| vector_addr | output | 12 | Vector-fetch address |
| mask_bit | output | 1 | Global interrupt mask |

## Verification
The arbiter is tried with single requests from each vector group and with all groups raised together, then drained one at a time. Draining shows that priority follows vector address and not the order in which requests were raised. Requests are held across cycles with no boundary strobe, which separates boundary-only sampling from immediate response. The same request is also tried with the mask set, with its enable cleared and with the mask later cleared, to show that a blocked request is deferred rather than dropped. The software trap is issued both with the mask set and alongside the external request, which confirms that it bypasses the mask and has top priority. Nested trap-inside-handler returns check that the mask stack is ordered last-in, first-out.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_HW  = 7;
  localparam int NUM_SRC = NUM_HW + 1;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int VEC_W   = 12;

  // source index: lower index = higher vector = higher priority
  localparam int SRC_SWI = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_CAP = 2;
  localparam int SRC_CMP = 3;
  localparam int SRC_TOV = 4;
  localparam int SRC_SCI = 5;
  localparam int SRC_COV = 6;
  localparam int SRC_RTT = 7;

  localparam logic [VEC_W-1:0] VEC_RESET = 12'hFFE;
  localparam logic [VEC_W-1:0] VEC_SWI   = 12'hFFC;
  localparam logic [VEC_W-1:0] VEC_EXT   = 12'hFFA;
  localparam logic [VEC_W-1:0] VEC_TMR   = 12'hFF8;
  localparam logic [VEC_W-1:0] VEC_SCI   = 12'hFF6;
  localparam logic [VEC_W-1:0] VEC_CTM   = 12'hFF4;

  function automatic logic [VEC_W-1:0] src_vector(input logic [IDX_W-1:0] idx);
    case (int'(idx))
      SRC_SWI:                   src_vector = VEC_SWI;
      SRC_EXT:                   src_vector = VEC_EXT;
      SRC_CAP, SRC_CMP, SRC_TOV: src_vector = VEC_TMR;
      SRC_SCI:                   src_vector = VEC_SCI;
      default:                   src_vector = VEC_CTM;
    endcase
  endfunction
endpackage

// File: rtl/irq_ext_sync.sv
module irq_ext_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  input  logic clr,
  output logic pend
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (rise)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  AST_PEND_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(rise)); // R7
  AST_PEND_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> $past(clr)); // R7
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]     req,
  output logic             valid,
  output logic [IDX_W-1:0] win_idx,
  output logic [VEC_W-1:0] win_vec
);
  always_comb begin
    valid   = 1'b0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid   = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
    win_vec = src_vector(win_idx);
  end

  always_comb begin
    AST_WIN_REQUESTED: assert (!valid || req[win_idx]); // R6
  end
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic push_val,
  input  logic pop,
  output logic top_val
);
  logic [DEPTH-1:0] stk;

  assign top_val = stk[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic from_above;
    logic from_below;
    if (i == DEPTH - 1) begin : g_top
      assign from_above = 1'b1;
    end else begin : g_mid
      assign from_above = stk[i+1];
    end
    if (i == 0) begin : g_head
      assign from_below = push_val;
    end else begin : g_rest
      assign from_below = stk[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst)       stk[i] <= 1'b1;
      else if (push) stk[i] <= from_below;
      else if (pop)  stk[i] <= from_above;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NEST_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_done,
  input  logic             swi_req,
  input  logic             ext_irq,
  input  logic [2:0]       tmr_req,
  input  logic             sci_req,
  input  logic [1:0]       ctm_req,
  input  logic [NUM_HW-1:0] src_en,
  input  logic             ibit_wr,
  input  logic             ibit_val,
  input  logic             rti,
  output logic             take_int,
  output logic [VEC_W-1:0] vector_addr,
  output logic             mask_bit
);
  logic                   ext_pend;
  logic [NUM_HW-1:0]      hw_req;
  logic [NUM_SRC-1:0]     eligible;
  logic                   arb_valid;
  logic [IDX_W-1:0]       arb_idx;
  logic [VEC_W-1:0]       arb_vec;
  logic                   take_now;
  logic                   stack_top;

  irq_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst(rst), .async_in(ext_irq),
    .clr(take_now && (arb_idx == IDX_W'(SRC_EXT))),
    .pend(ext_pend)
  );

  assign hw_req   = {ctm_req, sci_req, tmr_req, ext_pend};
  assign eligible = {hw_req & src_en & {NUM_HW{~mask_bit}}, swi_req};

  irq_prio_arb #(.N(NUM_SRC)) u_arb (
    .req(eligible), .valid(arb_valid), .win_idx(arb_idx), .win_vec(arb_vec)
  );

  assign take_now = instr_done & arb_valid;

  irq_mask_stack #(.DEPTH(NEST_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(take_now), .push_val(mask_bit),
    .pop(rti & ~take_now), .top_val(stack_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_int    <= 1'b0;
      vector_addr <= VEC_RESET;
      mask_bit    <= 1'b1;
    end else begin
      take_int <= take_now;
      if (take_now) begin
        vector_addr <= arb_vec;
        mask_bit    <= 1'b1;
      end else if (rti) begin
        mask_bit <= stack_top;
      end else if (ibit_wr) begin
        mask_bit <= ibit_val;
      end
    end
  end

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    take_int |-> $past(instr_done)); // R2
  AST_HW_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (take_int && vector_addr != VEC_SWI) |-> !$past(mask_bit)); // R3
  AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    take_int |-> mask_bit); // R5
  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    take_int |-> (vector_addr[VEC_W-1:4] == 8'hFF && !vector_addr[0])); // R6
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
    !take_int |-> $stable(vector_addr)); // R6
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_done = 1'b0, swi_req = 1'b0, ext_irq = 1'b0;
  logic [2:0]  tmr_req = '0;
  logic        sci_req = 1'b0;
  logic [1:0]  ctm_req = '0;
  logic [6:0]  src_en = 7'h7F;
  logic        ibit_wr = 1'b0, ibit_val = 1'b0, rti = 1'b0;
  logic        take_int, mask_bit;
  logic [11:0] vector_addr;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst(rst), .instr_done(instr_done), .swi_req(swi_req),
    .ext_irq(ext_irq), .tmr_req(tmr_req), .sci_req(sci_req), .ctm_req(ctm_req),
    .src_en(src_en), .ibit_wr(ibit_wr), .ibit_val(ibit_val), .rti(rti),
    .take_int(take_int), .vector_addr(vector_addr), .mask_bit(mask_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one instruction boundary; outputs then reflect that edge
  task automatic boundary(input logic swi);
    @(negedge clk); instr_done = 1'b1; swi_req = swi;
    @(negedge clk); instr_done = 1'b0; swi_req = 1'b0;
  endtask

  task automatic do_rti();
    @(negedge clk); rti = 1'b1;
    @(negedge clk); rti = 1'b0;
  endtask

  task automatic set_mask(input logic v);
    @(negedge clk); ibit_wr = 1'b1; ibit_val = v;
    @(negedge clk); ibit_wr = 1'b0;
  endtask

  task automatic expect_take(input string req, input int vec);
    chk({req, " take_int"}, int'(take_int), 1);
    chk({req, " vector"}, int'(vector_addr), vec);
    chk({req, " mask on entry R5"}, int'(mask_bit), 1);
    @(negedge clk);
    chk({req, " single pulse R2"}, int'(take_int), 0);
  endtask

  task automatic ext_edge();
    @(negedge clk); ext_irq = 1'b1;
    repeat (4) @(negedge clk);
    ext_irq = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 take_int", int'(take_int), 0);
    chk("R1 mask", int'(mask_bit), 1);
    chk("R1 vector", int'(vector_addr), 12'hFFE);
  endtask

  task automatic t_masked_hold();
    tmr_req[0] = 1'b1;
    boundary(1'b0);
    chk("R3 masked no take", int'(take_int), 0);
    set_mask(1'b0);
    chk("R9 mask cleared", int'(mask_bit), 0);
    boundary(1'b0);
    expect_take("R3 held timer", 12'hFF8);
    tmr_req[0] = 1'b0;
    do_rti();
    chk("R8 rti restores 0", int'(mask_bit), 0);
  endtask

  task automatic t_enable_gate();
    src_en[4] = 1'b0; sci_req = 1'b1;
    boundary(1'b0);
    chk("R3 disabled no take", int'(take_int), 0);
    src_en[4] = 1'b1;
    boundary(1'b0);
    expect_take("R3 enabled serial", 12'hFF6);
    sci_req = 1'b0;
    do_rti();
  endtask

  task automatic t_swi_masked();
    set_mask(1'b1);
    @(negedge clk); instr_done = 1'b1; swi_req = 1'b1; ibit_wr = 1'b1; ibit_val = 1'b0;
    @(negedge clk); instr_done = 1'b0; swi_req = 1'b0; ibit_wr = 1'b0;
    chk("R10 ibit_wr ignored on take", int'(mask_bit), 1);
    expect_take("R4 swi under mask", 12'hFFC);
    do_rti();
    chk("R8 rti restores 1", int'(mask_bit), 1);
    set_mask(1'b0);
  endtask

  task automatic t_mid_instr();
    @(negedge clk); ctm_req[1] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 no take mid-instruction", int'(take_int), 0);
    end
    boundary(1'b0);
    expect_take("R2 tick at boundary", 12'hFF4);
    ctm_req[1] = 1'b0;
    do_rti();
  endtask

  task automatic t_simultaneous();
    tmr_req[2] = 1'b1; sci_req = 1'b1; ctm_req = 2'b11;
    ext_edge();
    boundary(1'b0);
    expect_take("R6 ext wins all", 12'hFFA);
    do_rti();
    boundary(1'b0);
    expect_take("R6 timer next", 12'hFF8);
    tmr_req[2] = 1'b0; do_rti();
    boundary(1'b0);
    expect_take("R6 serial next", 12'hFF6);
    sci_req = 1'b0; do_rti();
    boundary(1'b0);
    expect_take("R6 core timer last", 12'hFF4);
    ctm_req = 2'b00; do_rti();
    boundary(1'b0);
    chk("R7 ext pending cleared", int'(take_int), 0);
    chk("R6 vector held", int'(vector_addr), 12'hFF4);
  endtask

  task automatic t_ext_sticky();
    src_en[0] = 1'b0;
    ext_edge();
    boundary(1'b0);
    chk("R7 disabled ext waits", int'(take_int), 0);
    src_en[0] = 1'b1;
    boundary(1'b0);
    expect_take("R7 sticky ext", 12'hFFA);
    do_rti();
  endtask

  task automatic t_swi_priority();
    ext_edge();
    boundary(1'b1);
    expect_take("R4 swi beats ext", 12'hFFC);
    do_rti();
    boundary(1'b0);
    expect_take("R7 ext still pending", 12'hFFA);
    do_rti();
  endtask

  task automatic t_nesting();
    tmr_req[1] = 1'b1;
    boundary(1'b0);
    expect_take("R8 outer", 12'hFF8);
    tmr_req[1] = 1'b0;
    boundary(1'b1);
    expect_take("R8 inner swi", 12'hFFC);
    do_rti();
    chk("R8 inner return", int'(mask_bit), 1);
    do_rti();
    chk("R8 outer return", int'(mask_bit), 0);
    do_rti();
    chk("R8 empty stack gives 1", int'(mask_bit), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masked_hold();
    t_enable_gate();
    t_swi_masked();
    t_mid_instr();
    t_simultaneous();
    t_ext_sticky();
    t_swi_priority();
    t_nesting();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule